// File: doc/BRIEF.md
# Four-Axis Interrupt Mask and Pending Aggregator

This block gathers the interrupt events of four counter axes into one shared, active-low interrupt line. Each axis supplies a one-cycle event pulse. The pulse latches a pending bit for that axis, and the bit stays set until the axis's own clear strobe removes it. A four-bit enable mask decides which pending bits may drive the shared line. The line is low while at least one axis is both pending and enabled.

Software reaches the block through the same 8-bit byte port that the counters use. A write changes only the enable mask. A read returns the mask and the pending bits together in one byte: the mask sits in the low nibble and the pending bits in the high nibble. In both nibbles, bit i belongs to axis i.

Top module: `irq_gather`

## Requirements
- R1: After reset, both the mask and the pending bits are 0, `rd_data` reads 8'h00 and `irq_n` is 1.
- R2: When `wr_en` is high at a clock edge, mask bit i takes `wr_data[i]` for i = 0..3. The new mask appears in `rd_data[3:0]` after that edge. A mask bit of 1 enables axis i and a 0 disables it.
- R3: A write ignores `wr_data[7:4]` and does not change any pending bit. While `wr_en` is low, the mask holds its value.
- R4: When `evt[i]` is high at a clock edge, pending bit i is set after that edge, whatever the mask holds. Pending bit i is read in `rd_data[4+i]`.
- R5: A pending bit stays set until `clr[i]` is high at an edge, and is then cleared after that edge. A clear affects only its own axis, and a pending bit never sets without an event.
- R6: If `evt[i]` and `clr[i]` are high at the same edge, pending bit i ends up set.
- R7: `irq_n` is 0 exactly when some axis has both its pending bit and its mask bit at 1. It follows register changes with no extra cycle of delay.
- R8: Clearing the mask bit of a pending axis releases `irq_n` for that axis but keeps its pending bit readable. Setting the mask bit again asserts `irq_n` once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe for the mask |
| wr_data | input | 8 | Write byte; the low nibble is the new mask |
| rd_data | output | 8 | Read byte: {pending[3:0], mask[3:0]} |
| evt | input | 4 | One-cycle event pulse per axis |
| clr | input | 4 | Clear strobe per axis |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The hardest case to reach from the ports is when, on one axis in one cycle, an event, a clear and a mask write that toggles that same axis all land together. The line state then depends on the set-over-clear priority and on the new mask at the same time. Random stimulus drives events, clears and writes with high densities, so these collisions occur many times. Directed steps also force the plain collision and the mask-off-while-pending sequence on a chosen axis.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int AXES = 4,
  localparam int BW = 2 * AXES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BW-1:0]   wr_data,
  output logic [BW-1:0]   rd_data,
  input  logic [AXES-1:0] evt,
  input  logic [AXES-1:0] clr,
  output logic            irq_n
);
  logic [AXES-1:0] mask_q;
  logic [AXES-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data[AXES-1:0];
  end

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (evt[i]) pend_q[i] <= 1'b1;
      else if (clr[i]) pend_q[i] <= 1'b0;
    end
  end

  assign rd_data = {pend_q, mask_q};
  assign irq_n   = ~|(pend_q & mask_q);
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int AXES = 4,
  localparam int BW = 2 * AXES
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [BW-1:0]   wr_data,
  input logic [BW-1:0]   rd_data,
  input logic [AXES-1:0] evt,
  input logic [AXES-1:0] clr,
  input logic            irq_n
);
  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[AXES-1:0] == $past(wr_data[AXES-1:0]));
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[AXES-1:0]));
  a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[BW-1:AXES] & $past(evt)) == $past(evt)));
  a_r5_hold_until_clr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rd_data[BW-1:AXES]) & ~$past(clr) & ~rd_data[BW-1:AXES]) == '0));
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[BW-1:AXES] & ~$past(rd_data[BW-1:AXES]) & ~$past(evt)) == '0));
  a_r5_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[BW-1:AXES] & $past(clr) & ~$past(evt)) == '0));
  a_r7_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((rd_data[BW-1:AXES] & rd_data[AXES-1:0]) == '0));
endmodule

bind irq_gather irq_gather_chk #(.AXES(AXES)) u_chk (.*);

// File: tb/test_irq_gather.sv
module test_irq_gather;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] evt = '0;
  logic [3:0] clr = '0;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  logic [3:0] m_mask = '0;
  logic [3:0] m_pend = '0;

  irq_gather i_irq_gather (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_byte(logic [3:0] p, logic [3:0] m);
    return {p, m};
  endfunction

  function automatic logic exp_line(logic [3:0] p, logic [3:0] m);
    return (p & m) == 4'h0;
  endfunction

  task automatic check(string tag);
    total++;
    if (rd_data !== exp_byte(m_pend, m_mask) || irq_n !== exp_line(m_pend, m_mask)) begin
      bad++;
      $display("FAIL %s rd=%h irq_n=%b expected rd=%h irq_n=%b", tag, rd_data, irq_n,
               exp_byte(m_pend, m_mask), exp_line(m_pend, m_mask));
    end
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic [3:0] e,
                      input logic [3:0] c, input string tag);
    wr_en = we; wr_data = wd; evt = e; clr = c;
    @(posedge clk);
    if (we) m_mask = wd[3:0];
    m_pend = (m_pend & ~c) | e;
    @(negedge clk);
    wr_en = 1'b0; evt = '0; clr = '0;
    check(tag);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
    step(1'b1, 8'hF5, 4'h0, 4'h0, "R2 R3 write with upper nibble");
    step(1'b0, 8'hFF, 4'h0, 4'h0, "R3 no write holds mask");
    step(1'b0, 8'h00, 4'b0010, 4'h0, "R4 masked event sets pending");
    step(1'b0, 8'h00, 4'b0001, 4'h0, "R4 R7 enabled event asserts line");
    step(1'b1, 8'hF4, 4'h0, 4'h0, "R8 mask off pending axis");
    step(1'b0, 8'h00, 4'h0, 4'h0, "R5 pending holds");
    step(1'b1, 8'h05, 4'h0, 4'h0, "R8 re-enable pending axis");
    step(1'b0, 8'h00, 4'h0, 4'b0001, "R5 clear only axis 0");
    step(1'b0, 8'h00, 4'b0100, 4'b0110, "R6 set beats clear");
    step(1'b0, 8'h00, 4'h0, 4'hF, "R5 clear all");
    step(1'b1, 8'h0F, 4'b1000, 4'h0, "R7 write and event together");
    for (int n = 0; n < 3000; n++) begin
      logic       we;
      logic [7:0] wd;
      logic [3:0] e;
      logic [3:0] c;
      we = ($urandom % 4) == 0;
      wd = 8'($urandom);
      e  = 4'($urandom) & 4'($urandom);
      c  = 4'($urandom) & 4'($urandom);
      step(we, wd, e, c, "R2-mix random R4 R5 R6 R7");
    end
    rst_n = 1'b0;
    @(posedge clk);
    m_mask = '0; m_pend = '0;
    @(negedge clk);
    check("R1 reset again");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule